// File: doc/BRIEF.md
# Power Mode Control Register

This block holds the 8-bit power control register of a small microcontroller core. It also runs the state machine that moves the core between normal running, idle and power-down. The CPU writes the register over a simple write strobe with a data byte. The current contents are always visible on a read-data bus. Three fields go straight out to other logic:
- the baud-rate doubler for the serial port,
- the select that turns the serial control register's top bit into a framing-error flag,
- two general-purpose flags.

The low two bits request the low-power modes. A write that sets the idle bit moves the state machine from RUN to IDLE. A write that sets the power-down bit moves it from RUN to DOWN, but only while the external power-down enable pin is high. When both bits are written as 1 and the pin is high, DOWN wins. The named transitions are:
- RUN→IDLE on an idle request.
- RUN→DOWN on an allowed power-down request.
- IDLE→RUN and DOWN→RUN on a wake event.
- Any state→RUN on either reset.

The other paths hold their state (RUN→RUN, IDLE→IDLE, DOWN→DOWN). The state is reflected in register bits 1 and 0 and on the two request outputs.

There are two resets. A power-on reset clears everything and sets the power-off flag, so software can tell a cold start from a warm one. A warm reset clears everything except that flag. The flag then keeps its value until software writes it.

Top module: `pmc_ctrl`

## Requirements
- R1: A write stores data bit 7 (baud doubler), bit 6 (framing-error select) and bits 3..2 (general-purpose flags). These read back at the same positions from the next cycle, and appear on `baud_double`, `fe_select` and `gp_flags`.
- R2: Read-data bit 5 is always 0, whatever was written there.
- R3: While power-on reset is low, and after it is released, the register reads 8'h10: only bit 4, the power-off flag, is set. Any earlier state is cleared.
- R4: A warm reset clears every bit and returns the state to RUN, but leaves bit 4 at its previous value.
- R5: A write loads data bit 4 into the power-off flag. Nothing else except power-on reset changes it.
- R6: In RUN, a write with bit 0 = 1 (and no accepted power-down) enters IDLE on the next cycle. Read bit 0 and `idle_req` are then 1.
- R7: In RUN, a write with bit 1 = 1 enters DOWN only if `pd_enable` is high in that cycle. With the pin low, bit 1 of the write has no effect.
- R8: In RUN, a write with bits 1 and 0 both 1 and the pin high enters DOWN, not IDLE. With the pin low, the same write enters IDLE.
- R9: In IDLE or DOWN, `wake` high returns to RUN on the next cycle. In RUN, `wake` has no effect.
- R10: In IDLE or DOWN, bits 1..0 of a write are ignored and the state holds. The other fields are still written.
- R11: `idle_req` equals read bit 0 and `pdown_req` equals read bit 1. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Warm reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register contents |
| pd_enable | input | 1 | External pin that allows power-down entry |
| wake | input | 1 | Enabled wake interrupt |
| idle_req | output | 1 | Idle mode active |
| pdown_req | output | 1 | Power-down mode active |
| baud_double | output | 1 | Baud-rate doubler to the serial port |
| fe_select | output | 1 | Framing-error select to the serial port |
| gp_flags | output | 2 | General-purpose flags |

## Verification
Some properties are checked on every cycle:
- The two mode requests are never high together.
- Power-down is never entered without the enable pin and a write in the previous cycle.
- A wake in a low-power state always lands in RUN.
- The power-off flag holds whenever there is no write.
- Written fields appear one cycle after the write.

Other behaviour only the bench scenarios can show. These are: the exact values after each kind of reset, that bit 4 survives a warm reset, the precedence of power-down over idle, and that mode writes are ignored while idle or powered down. A seeded random sequence of writes, pin levels and wakes is compared against a bench model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pm_state_e;

    // Field positions inside the control byte
    localparam int unsigned POS_IDLE = 0;
    localparam int unsigned POS_DOWN = 1;
    localparam int unsigned POS_GP_LO = 2;
    localparam int unsigned GP_W = 2;
    localparam int unsigned POS_POF = 4;
    localparam int unsigned POS_RSVD = 5;
    localparam int unsigned POS_FESEL = 6;
    localparam int unsigned POS_BAUD = 7;
endpackage

// File: rtl/pmc_fields.sv
module pmc_fields
    import pmc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              arst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              baud,
    output logic              fesel,
    output logic [GP_W-1:0]   gp,
    output logic              pof
);
    // Fields cleared by either reset
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            baud  <= 1'b0;
            fesel <= 1'b0;
            gp    <= '0;
        end else if (wr) begin
            baud  <= wdata[POS_BAUD];
            fesel <= wdata[POS_FESEL];
            gp    <= wdata[POS_GP_LO +: GP_W];
        end
    end

    // Power-off flag: only the power-on reset touches it asynchronously
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pof <= 1'b1;
        end else if (wr) begin
            pof <= wdata[POS_POF];
        end
    end

    a_r5_pof_holds: assert property (@(posedge clk) disable iff (!por_n)
        !wr |=> $stable(pof));

    a_r1_fields_load: assert property (@(posedge clk) disable iff (!arst_n)
        wr |=> (baud == $past(wdata[POS_BAUD])) && (fesel == $past(wdata[POS_FESEL])));
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic mode_wr,
    input  logic want_idle,
    input  logic want_down,
    input  logic down_allow,
    input  logic wake,
    output logic idle_req,
    output logic down_req
);
    pm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= PM_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (mode_wr && want_down && down_allow) state_d = PM_DOWN;
                else if (mode_wr && want_idle)          state_d = PM_IDLE;
            end
            PM_IDLE: if (wake) state_d = PM_RUN;
            PM_DOWN: if (wake) state_d = PM_RUN;
            default: state_d = PM_RUN;
        endcase
    end

    always_comb begin
        idle_req = (state_q == PM_IDLE);
        down_req = (state_q == PM_DOWN);
    end

    a_r11_one_mode: assert property (@(posedge clk) disable iff (!arst_n)
        $onehot0({idle_req, down_req}));

    a_r7_down_needs_pin: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(down_req) |-> $past(mode_wr && want_down && down_allow));

    a_r9_wake_exits: assert property (@(posedge clk) disable iff (!arst_n)
        (wake && (idle_req || down_req)) |=> !idle_req && !down_req);

    a_r10_low_power_holds: assert property (@(posedge clk) disable iff (!arst_n)
        (!wake && (idle_req || down_req)) |=> $stable({idle_req, down_req}));
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pd_enable,
    input  logic              wake,
    output logic              idle_req,
    output logic              pdown_req,
    output logic              baud_double,
    output logic              fe_select,
    output logic [GP_W-1:0]   gp_flags
);
    logic any_rst_n;
    logic pof;

    assign any_rst_n = por_n & rst_n;

    pmc_fields #(.DATA_W(DATA_W)) u_fields (
        .clk    (clk),
        .por_n  (por_n),
        .arst_n (any_rst_n),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .baud   (baud_double),
        .fesel  (fe_select),
        .gp     (gp_flags),
        .pof    (pof)
    );

    pmc_mode_fsm u_fsm (
        .clk        (clk),
        .arst_n     (any_rst_n),
        .mode_wr    (reg_wr),
        .want_idle  (reg_wdata[POS_IDLE]),
        .want_down  (reg_wdata[POS_DOWN]),
        .down_allow (pd_enable),
        .wake       (wake),
        .idle_req   (idle_req),
        .down_req   (pdown_req)
    );

    always_comb begin
        reg_rdata = '0;
        reg_rdata[POS_BAUD]            = baud_double;
        reg_rdata[POS_FESEL]           = fe_select;
        reg_rdata[POS_POF]             = pof;
        reg_rdata[POS_GP_LO +: GP_W]   = gp_flags;
        reg_rdata[POS_DOWN]            = pdown_req;
        reg_rdata[POS_IDLE]            = idle_req;
    end

    a_r4_warm_keeps_pof: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && $past(!reg_wr)) |-> reg_rdata[POS_POF] == $past(reg_rdata[POS_POF]));
endmodule

// File: tb/pmc_ctrl_bench.sv
module pmc_ctrl_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pd_enable = 1'b0;
    logic       wake = 1'b0;
    logic       idle_req, pdown_req, baud_double, fe_select;
    logic [1:0] gp_flags;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [7:0] m_fields;   // bits 7,6,4,3,2 only
    int         m_state;    // 0 run, 1 idle, 2 down

    always #5 clk = ~clk;

    pmc_ctrl u_pmc_ctrl (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pd_enable(pd_enable),
        .wake(wake), .idle_req(idle_req), .pdown_req(pdown_req),
        .baud_double(baud_double), .fe_select(fe_select), .gp_flags(gp_flags)
    );

    function automatic logic [7:0] exp_byte();
        return (m_fields & 8'hDC) | {6'b0, m_state == 2, m_state == 1};
    endfunction

    function automatic int next_state(int st, logic wr, logic [7:0] d, logic pin, logic wk);
        if (st == 0) begin
            if (wr && d[1] && pin) return 2;
            if (wr && d[0]) return 1;
            return 0;
        end
        return wk ? 0 : st;
    endfunction

    task automatic check(string tag);
        logic [7:0] e;
        e = exp_byte();
        checks++;
        if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s: rdata actual=%h expected=%h", tag, reg_rdata, e);
        end
        checks++;
        if ({baud_double, fe_select, gp_flags, pdown_req, idle_req} !== {e[7], e[6], e[3:2], e[1], e[0]}) begin
            errors++;
            $display("FAIL %s: outputs actual=%b expected=%b", tag,
                {baud_double, fe_select, gp_flags, pdown_req, idle_req},
                {e[7], e[6], e[3:2], e[1], e[0]});
        end
    endtask

    task automatic step(logic wr, logic [7:0] d, logic pin, logic wk, string tag);
        reg_wr = wr; reg_wdata = d; pd_enable = pin; wake = wk;
        @(posedge clk);
        m_state = next_state(m_state, wr, d, pin, wk);
        if (wr) m_fields = d & 8'hDC;
        @(negedge clk);
        reg_wr = 1'b0; wake = 1'b0;
        check(tag);
    endtask

    task automatic power_on(string tag);
        @(negedge clk);
        por_n = 1'b0;
        m_fields = 8'h10; m_state = 0;
        @(negedge clk);
        check(tag);
        por_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check(tag);
    endtask

    task automatic warm_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0;
        m_fields = m_fields & 8'h10; m_state = 0;
        @(negedge clk);
        check(tag);
        rst_n = 1'b1;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        m_fields = 8'h10; m_state = 0;
        void'($urandom(32'h5EED_0C1A));
        // R3: cold start
        power_on("R3 power-on");
        // R2 R7 R8: all ones, pin low -> idle, reserved 0
        step(1'b1, 8'hFF, 1'b0, 1'b0, "R2 R8 pin low all ones");
        step(1'b0, 8'h00, 1'b1, 1'b1, "R9 wake from idle");
        // R8 R5: both bits with pin high -> down, pof cleared
        step(1'b1, 8'h03, 1'b1, 1'b0, "R8 R5 down wins");
        step(1'b1, 8'h01, 1'b1, 1'b0, "R10 write in down");
        step(1'b0, 8'h00, 1'b0, 1'b1, "R9 wake from down");
        step(1'b0, 8'h00, 1'b1, 1'b1, "R9 wake in run");
        step(1'b1, 8'h02, 1'b0, 1'b0, "R7 pin low ignored");
        step(1'b1, 8'h02, 1'b1, 1'b0, "R7 pin high down");
        step(1'b1, 8'h03, 1'b1, 1'b1, "R9 wake with write");
        step(1'b1, 8'h01, 1'b1, 1'b0, "R6 idle");
        step(1'b1, 8'h02, 1'b1, 1'b0, "R10 write in idle");
        step(1'b0, 8'h00, 1'b1, 1'b1, "R9 wake idle");
        step(1'b1, 8'hEC, 1'b0, 1'b0, "R1 R2 fields");
        warm_reset("R4 warm pof clear");
        step(1'b1, 8'h11, 1'b0, 1'b0, "R5 R6 pof set idle");
        warm_reset("R4 warm pof kept");
        step(1'b1, 8'h02, 1'b1, 1'b0, "R7 down before por");
        power_on("R3 por from down");
        // random phase
        for (int i = 0; i < 400; i++) begin
            logic       wr, pin, wk;
            logic [7:0] d;
            wr  = ($urandom % 2) == 0;
            d   = 8'($urandom);
            pin = ($urandom % 4) != 0;
            wk  = ($urandom % 4) == 0;
            step(wr, d, pin, wk, "R11 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule